// File: doc/BRIEF.md
# Clock Synthesizer Divider Search Engine

This block works out the programming word for a PLL-style clock synthesizer whose output is a reference frequency scaled by a multiplier over a divisor. A request gives a target frequency in 10 kHz units. The engine first conditions that target. A zero request becomes a default rate. An optional halving lets an external clock doubler reach the rest. Repeated doubling lifts a low target into the synthesizer's working band, and the number of doublings is recorded as a post-divider exponent. The engine then picks a band index from a fixed threshold list.

The engine then walks every multiplier/divisor pair. It evaluates one candidate per clock through a pipelined divider and keeps the pair whose output frequency is nearest the conditioned target. When the walk ends it packs band index, multiplier, exponent, divisor and a register-select code into one word and pulses `done`. Shifting the word out to the synthesizer is left to another block.

Top module: `cs_synth_search`

## Requirements
- R1: A requested frequency of 0 is handled exactly as a request of 3150.
- R2: When the (zero-substituted) target is greater than `freq_max` and `dbl_allow` is 1, the target is halved (rounding down) and `dbl_on` reads 1 after completion. Otherwise the target is kept and `dbl_on` reads 0.
- R3: While the target is below 5000 and the exponent m is below 7, the target is doubled and m is increased by one. m starts at 0 and is placed in word bits [9:7].
- R4: The band index in word bits [20:17] is the position (0 to 15) of the first entry greater than the conditioned target in the list 5100, 5320, 5850, 6070, 6440, 6680, 7350, 7560, 8090, 8320, 9150, 10000, 12000, 12000, 12000, 12000. The index is 0 when no entry is greater.
- R5: Multiplier p (bits [16:10]) and divisor q (bits [6:0]) are chosen over p = 0..127 and q from floor(5727*(p+3)/32767) up to 127. The chosen pair minimises |target - floor(5727*(p+3)/(2*(q+2)))|. On equal error, the pair met first with p in the outer loop and q in the inner loop, both ascending, wins.
- R6: A pair is accepted only if its error is strictly below 10000 and below every earlier error. If no pair qualifies, p and q are both 0.
- R7: Word bits [23:21] carry 3'b010 when `sel_mem` was 0 at start, and 3'b101 when it was 1.
- R8: `busy` is 1 from the cycle after an accepted `start` until the search ends. `done` is then 1 for exactly one cycle with `busy` at 0. A `start` seen while `busy` is 1 is ignored.
- R9: After reset `prog_word` and `dbl_on` are 0. They change only in the cycle `done` is 1 and otherwise hold their last value, including throughout a following search.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a search; sampled only while idle |
| freq_req | input | 16 | Target frequency, 10 kHz units |
| freq_max | input | 16 | Highest target used without the doubler |
| dbl_allow | input | 1 | Permit halving with the external doubler |
| sel_mem | input | 1 | 1 selects the memory-clock register code, 0 the pixel-clock code |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| prog_word | output | 24 | Packed synthesizer programming word |
| dbl_on | output | 1 | External doubler required for the last result |

## Verification
The bench builds the block with its default parameters: 7-bit multiplier and divisor, 3-bit exponent, 16-bit frequency, and the 5727 reference with a 32767 floor divisor. At these values one search of about fifteen thousand candidates takes well under twenty thousand cycles, so several full searches fit in a run. Each one is compared with an exhaustive model in the bench. These settings also reach the saturating exponent (a 30-unit request), the no-greater-entry band case, and the case where no pair beats the initial error of 10000 (a 40000 request with the doubler barred).

// File: rtl/cs_pkg.sv
// Shared types and the band-threshold lookup for the synthesizer search engine.
// Assumes frequencies are unsigned values in 10 kHz units.
package cs_pkg;

    typedef enum logic [1:0] {ST_IDLE, ST_SCALE, ST_SEARCH, ST_DRAIN} cs_state_e;

    localparam int BAND_N = 16;

    // Threshold for band slot k; the top slots repeat the last rate.
    function automatic logic [15:0] band_edge(input int k);
        case (k)
            0:       return 16'd5100;
            1:       return 16'd5320;
            2:       return 16'd5850;
            3:       return 16'd6070;
            4:       return 16'd6440;
            5:       return 16'd6680;
            6:       return 16'd7350;
            7:       return 16'd7560;
            8:       return 16'd8090;
            9:       return 16'd8320;
            10:      return 16'd9150;
            11:      return 16'd10000;
            default: return 16'd12000;
        endcase
    endfunction

    // First slot whose threshold exceeds f; slot 0 when none does.
    function automatic logic [3:0] band_lookup(input logic [31:0] f);
        logic [3:0] idx;
        logic       hit;
        idx = '0;
        hit = 1'b0;
        for (int k = 0; k < BAND_N; k++) begin
            if (!hit && (f < {16'd0, band_edge(k)})) begin
                idx = 4'(k);
                hit = 1'b1;
            end
        end
        return idx;
    endfunction

endpackage

// File: rtl/cs_cand_gen.sv
// Candidate walker: issues one (p, q, numerator) triple per clock, p outer and
// q inner, both ascending. q starts each row at floor(REF*(p+3)/QS_DIV).
// Assumes REF_FREQ < QS_DIV, so the floor grows by at most one per row, and
// that the floor never exceeds the largest q.
module cs_cand_gen #(
    parameter int P_BITS   = 7,
    parameter int Q_BITS   = 7,
    parameter int REF_FREQ = 5727,
    parameter int QS_DIV   = 32767,
    parameter int NUM_W    = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    output logic              issue,
    output logic              last,
    output logic [P_BITS-1:0] cand_p,
    output logic [Q_BITS-1:0] cand_q,
    output logic [NUM_W-1:0]  cand_num
);
    localparam int P_MAX   = (1 << P_BITS) - 1;
    localparam int Q_MAX   = (1 << Q_BITS) - 1;
    localparam int QS0     = (REF_FREQ * 3) / QS_DIV;
    localparam int NUM_TOP = REF_FREQ * (P_MAX + 3);
    localparam int THR_W   = $clog2(NUM_TOP + 2 * QS_DIV + 1);
    localparam logic [P_BITS-1:0] P_MAX_V = P_BITS'(P_MAX);
    localparam logic [Q_BITS-1:0] Q_MAX_V = Q_BITS'(Q_MAX);
    localparam logic [Q_BITS-1:0] QS0_V   = Q_BITS'(QS0);

    logic              act_r;
    logic [P_BITS-1:0] p_r;
    logic [Q_BITS-1:0] q_r;
    logic [Q_BITS-1:0] qs_r;
    logic [NUM_W-1:0]  num_r;
    logic [THR_W-1:0]  thr_r;    // (qs_r + 1) * QS_DIV
    logic [THR_W-1:0]  num_nxt;

    // Numerator of the next row.
    assign num_nxt = THR_W'(num_r) + THR_W'(REF_FREQ);

    // Walk the candidate space; track the q floor without a divider.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_r <= 1'b0;
            p_r   <= '0;
            q_r   <= '0;
            qs_r  <= '0;
            num_r <= '0;
            thr_r <= '0;
        end else if (launch) begin
            act_r <= 1'b1;
            p_r   <= '0;
            q_r   <= QS0_V;
            qs_r  <= QS0_V;
            num_r <= NUM_W'(REF_FREQ * 3);
            thr_r <= THR_W'((QS0 + 1) * QS_DIV);
        end else if (act_r) begin
            if (q_r == Q_MAX_V) begin
                if (p_r == P_MAX_V) begin
                    act_r <= 1'b0;
                end else begin
                    p_r   <= p_r + 1'b1;
                    num_r <= NUM_W'(num_nxt);
                    if (num_nxt >= thr_r) begin
                        qs_r  <= qs_r + 1'b1;
                        q_r   <= qs_r + 1'b1;
                        thr_r <= thr_r + THR_W'(QS_DIV);
                    end else begin
                        q_r <= qs_r;
                    end
                end
            end else begin
                q_r <= q_r + 1'b1;
            end
        end
    end

    assign issue    = act_r;
    assign last     = act_r && (p_r == P_MAX_V) && (q_r == Q_MAX_V);
    assign cand_p   = p_r;
    assign cand_q   = q_r;
    assign cand_num = num_r;

    // R5: every issued q lies at or above the row floor.
    a_r5_q_at_floor: assert property (@(posedge clk) disable iff (!rst_n)
        act_r |-> (q_r >= qs_r));

    // R5: the floor bound stays ahead of the running numerator.
    a_r5_floor_bound: assert property (@(posedge clk) disable iff (!rst_n)
        act_r |-> (THR_W'(num_r) < thr_r));

endmodule

// File: rtl/cs_pipe_div.sv
// Pipelined restoring divider: one quotient bit per stage, NUM_W stages, one
// new operand pair accepted every clock. A tag and a valid bit travel with
// each operand. Assumes the divisor is never zero.
module cs_pipe_div #(
    parameter int NUM_W = 20,
    parameter int DEN_W = 9,
    parameter int TAG_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [NUM_W-1:0] in_num,
    input  logic [DEN_W-1:0] in_den,
    input  logic [TAG_W-1:0] in_tag,
    output logic             out_valid,
    output logic [NUM_W-1:0] out_quo,
    output logic [TAG_W-1:0] out_tag,
    output logic             any_valid
);
    logic [NUM_W-1:0] v_vec;

    for (genvar k = 0; k < NUM_W; k++) begin : g_stage
        localparam int NI = NUM_W - k;    // numerator bits not yet consumed
        logic             vi;
        logic [NI-1:0]    ni;
        logic [DEN_W-1:0] ri;
        logic [DEN_W-1:0] di;
        logic [TAG_W-1:0] ti;
        logic [DEN_W:0]   trial;
        logic             ge;
        logic             v_q;
        logic [k:0]       quo_q;
        logic [TAG_W-1:0] tag_q;

        if (k == 0) begin : g_src
            assign vi = in_valid;
            assign ni = in_num;
            assign ri = '0;
            assign di = in_den;
            assign ti = in_tag;
            // First quotient bit.
            always_ff @(posedge clk) quo_q <= ge;
        end else begin : g_src
            assign vi = g_stage[k-1].v_q;
            assign ni = g_stage[k-1].g_fwd.num_q;
            assign ri = g_stage[k-1].g_fwd.rem_q;
            assign di = g_stage[k-1].g_fwd.den_q;
            assign ti = g_stage[k-1].tag_q;
            // Append this stage's quotient bit.
            always_ff @(posedge clk) quo_q <= {g_stage[k-1].quo_q, ge};
        end

        assign trial = {ri, ni[NI-1]};
        assign ge    = (trial >= {1'b0, di});

        // Valid flag, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) v_q <= 1'b0;
            else        v_q <= vi;
        end

        // Tag rides along unchanged.
        always_ff @(posedge clk) tag_q <= ti;

        if (k < NUM_W - 1) begin : g_fwd
            logic [NI-2:0]    num_q;
            logic [DEN_W-1:0] rem_q;
            logic [DEN_W-1:0] den_q;
            logic [DEN_W-1:0] rnext;
            assign rnext = ge ? DEN_W'(trial - {1'b0, di}) : DEN_W'(trial);
            // Hand remaining numerator, partial remainder and divisor onward.
            always_ff @(posedge clk) begin
                num_q <= ni[NI-2:0];
                rem_q <= rnext;
                den_q <= di;
            end
        end

        assign v_vec[k] = v_q;
    end

    assign out_valid = g_stage[NUM_W-1].v_q;
    assign out_quo   = g_stage[NUM_W-1].quo_q;
    assign out_tag   = g_stage[NUM_W-1].tag_q;
    assign any_valid = |v_vec;

endmodule

// File: rtl/cs_best_track.sv
// Keeps the candidate nearest the target. A candidate wins only with a
// strictly smaller absolute error, so the earliest of equal errors survives.
// Assumes candidates arrive in search order.
module cs_best_track #(
    parameter int FREQ_W    = 16,
    parameter int NUM_W     = 20,
    parameter int P_BITS    = 7,
    parameter int Q_BITS    = 7,
    parameter int BEST_INIT = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              cand_valid,
    input  logic [FREQ_W-1:0] target,
    input  logic [NUM_W-1:0]  cand_freq,
    input  logic [P_BITS-1:0] cand_p,
    input  logic [Q_BITS-1:0] cand_q,
    output logic [P_BITS-1:0] best_p,
    output logic [Q_BITS-1:0] best_q
);
    localparam int EW = ((FREQ_W > NUM_W) ? FREQ_W : NUM_W) + 1;

    logic [EW-1:0] tgt_x;
    logic [EW-1:0] cf_x;
    logic [EW-1:0] err;
    logic [EW-1:0] best_err;
    logic          better;

    // Absolute distance between target and candidate output.
    always_comb begin
        tgt_x  = EW'(target);
        cf_x   = EW'(cand_freq);
        err    = (tgt_x >= cf_x) ? (tgt_x - cf_x) : (cf_x - tgt_x);
        better = cand_valid && (err < best_err);
    end

    // Record the winning pair and its error.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            best_err <= EW'(BEST_INIT);
            best_p   <= '0;
            best_q   <= '0;
        end else if (better) begin
            best_err <= err;
            best_p   <= cand_p;
            best_q   <= cand_q;
        end
    end

    // R6: the kept error never grows during a search.
    a_r6_err_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (best_err <= $past(best_err)));

    // R6: the kept error never exceeds the initial bound.
    a_r6_err_bound: assert property (@(posedge clk) disable iff (!rst_n)
        best_err <= EW'(BEST_INIT));

endmodule

// File: rtl/cs_synth_search.sv
// Top of the synthesizer parameter search. It conditions the target
// (zero default, optional halving, doubling into band with exponent m) and
// picks the band index. It then runs the candidate walker through the
// pipelined divider into the best tracker and packs the result word.
// Assumes start is a level sampled only while idle.
module cs_synth_search
    import cs_pkg::*;
#(
    parameter int          FREQ_W      = 16,
    parameter int          P_BITS      = 7,
    parameter int          Q_BITS      = 7,
    parameter int          M_BITS      = 3,
    parameter int          IDX_W       = 4,
    parameter int          SEL_W       = 3,
    parameter int          REF_FREQ    = 5727,
    parameter int          QS_DIV      = 32767,
    parameter int          BEST_INIT   = 10000,
    parameter int          ZERO_FREQ   = 3150,
    parameter int          SCALE_FLOOR = 5000,
    parameter logic [2:0]  SEL_PIX     = 3'b010,
    parameter logic [2:0]  SEL_MEM     = 3'b101,
    localparam int         WORD_W      = SEL_W + IDX_W + P_BITS + M_BITS + Q_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FREQ_W-1:0] freq_req,
    input  logic [FREQ_W-1:0] freq_max,
    input  logic              dbl_allow,
    input  logic              sel_mem,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] prog_word,
    output logic              dbl_on
);
    localparam int P_MAX   = (1 << P_BITS) - 1;
    localparam int NUM_TOP = REF_FREQ * (P_MAX + 3);
    localparam int NUM_W   = $clog2(NUM_TOP + 1);
    localparam int DEN_W   = Q_BITS + 2;
    localparam int TAG_W   = P_BITS + Q_BITS;
    localparam logic [FREQ_W-1:0] ZERO_V  = FREQ_W'(ZERO_FREQ);
    localparam logic [FREQ_W-1:0] FLOOR_V = FREQ_W'(SCALE_FLOOR);
    localparam logic [M_BITS-1:0] M_MAX_V = M_BITS'((1 << M_BITS) - 1);

    cs_state_e         state;
    logic [FREQ_W-1:0] f_r;
    logic [M_BITS-1:0] m_r;
    logic [IDX_W-1:0]  idx_r;
    logic              sel_r;
    logic              dbl_r;
    logic              done_r;
    logic [WORD_W-1:0] word_r;
    logic              dbl_on_r;

    logic [FREQ_W-1:0] f0;
    logic              halve;
    logic              scale_more;
    logic              launch;

    logic              gen_issue;
    logic              gen_last;
    logic [P_BITS-1:0] cand_p;
    logic [Q_BITS-1:0] cand_q;
    logic [NUM_W-1:0]  cand_num;
    logic [DEN_W-2:0]  q_plus2;
    logic [DEN_W-1:0]  cand_den;

    logic              div_valid;
    logic [NUM_W-1:0]  div_quo;
    logic [TAG_W-1:0]  div_tag;
    logic              pipe_busy;
    logic [P_BITS-1:0] best_p;
    logic [Q_BITS-1:0] best_q;
    logic [SEL_W-1:0]  sel_code;

    // Entry conditioning: zero default, then optional halving.
    always_comb begin
        f0    = (freq_req == '0) ? ZERO_V : freq_req;
        halve = (f0 > freq_max) && dbl_allow;
    end

    assign scale_more = (f_r < FLOOR_V) && (m_r != M_MAX_V);
    assign launch     = (state == ST_SCALE) && !scale_more;
    assign q_plus2    = (DEN_W-1)'(cand_q) + (DEN_W-1)'(2);
    assign cand_den   = {q_plus2, 1'b0};
    assign sel_code   = sel_r ? SEL_W'(SEL_MEM) : SEL_W'(SEL_PIX);

    // Sequencer: accept, scale into band, search, drain, publish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            f_r      <= '0;
            m_r      <= '0;
            idx_r    <= '0;
            sel_r    <= 1'b0;
            dbl_r    <= 1'b0;
            done_r   <= 1'b0;
            word_r   <= '0;
            dbl_on_r <= 1'b0;
        end else begin
            done_r <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        f_r   <= halve ? (f0 >> 1) : f0;
                        dbl_r <= halve;
                        m_r   <= '0;
                        sel_r <= sel_mem;
                        state <= ST_SCALE;
                    end
                end
                ST_SCALE: begin
                    if (scale_more) begin
                        f_r <= f_r << 1;
                        m_r <= m_r + 1'b1;
                    end else begin
                        idx_r <= IDX_W'(band_lookup(32'(f_r)));
                        state <= ST_SEARCH;
                    end
                end
                ST_SEARCH: begin
                    if (gen_last) state <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (!pipe_busy) begin
                        word_r   <= {sel_code, idx_r, best_p, m_r, best_q};
                        dbl_on_r <= dbl_r;
                        done_r   <= 1'b1;
                        state    <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    cs_cand_gen #(
        .P_BITS  (P_BITS),
        .Q_BITS  (Q_BITS),
        .REF_FREQ(REF_FREQ),
        .QS_DIV  (QS_DIV),
        .NUM_W   (NUM_W)
    ) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .issue   (gen_issue),
        .last    (gen_last),
        .cand_p  (cand_p),
        .cand_q  (cand_q),
        .cand_num(cand_num)
    );

    cs_pipe_div #(
        .NUM_W(NUM_W),
        .DEN_W(DEN_W),
        .TAG_W(TAG_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (gen_issue),
        .in_num   (cand_num),
        .in_den   (cand_den),
        .in_tag   ({cand_p, cand_q}),
        .out_valid(div_valid),
        .out_quo  (div_quo),
        .out_tag  (div_tag),
        .any_valid(pipe_busy)
    );

    cs_best_track #(
        .FREQ_W   (FREQ_W),
        .NUM_W    (NUM_W),
        .P_BITS   (P_BITS),
        .Q_BITS   (Q_BITS),
        .BEST_INIT(BEST_INIT)
    ) u_best (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (launch),
        .cand_valid(div_valid),
        .target    (f_r),
        .cand_freq (div_quo),
        .cand_p    (div_tag[TAG_W-1:Q_BITS]),
        .cand_q    (div_tag[Q_BITS-1:0]),
        .best_p    (best_p),
        .best_q    (best_q)
    );

    assign busy      = (state != ST_IDLE);
    assign done      = done_r;
    assign prog_word = word_r;
    assign dbl_on    = dbl_on_r;

    // R8: completion lasts a single cycle.
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: completion is never reported while still busy.
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R3: the search always runs on a scaled target or a saturated exponent.
    a_r3_scaled: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEARCH) |-> ((f_r >= FLOOR_V) || (m_r == M_MAX_V)));

    // R9: the published word moves only together with done.
    a_r9_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prog_word) |-> done);

    // R9: the doubler flag moves only together with done.
    a_r9_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dbl_on) |-> done);

endmodule

// File: tb/sim_cs_synth_search.sv
module sim_cs_synth_search;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [15:0] freq_req;
    logic [15:0] freq_max;
    logic        dbl_allow;
    logic        sel_mem;
    logic        busy;
    logic        done;
    logic [23:0] prog_word;
    logic        dbl_on;

    int          checks = 0;
    int          errors = 0;
    logic [23:0] prev_word = '0;
    logic        prev_dbl = 1'b0;

    always #5 clk = ~clk;

    cs_synth_search u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .freq_req (freq_req),
        .freq_max (freq_max),
        .dbl_allow(dbl_allow),
        .sel_mem  (sel_mem),
        .busy     (busy),
        .done     (done),
        .prog_word(prog_word),
        .dbl_on   (dbl_on)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int edge_of(input int k);
        case (k)
            0: return 5100;   1: return 5320;   2: return 5850;   3: return 6070;
            4: return 6440;   5: return 6680;   6: return 7350;   7: return 7560;
            8: return 8090;   9: return 8320;  10: return 9150;  11: return 10000;
            default: return 12000;
        endcase
    endfunction

    // Exhaustive reference built from the requirements.
    task automatic model(input int freq, input int fmax, input bit allow, input bit mem,
                         output logic [23:0] word, output bit dbl);
        int f, m, idx, bp, bq, bd;
        f = (freq == 0) ? 3150 : freq;                        // R1
        dbl = (f > fmax) && allow;                            // R2
        if (dbl) f = f / 2;
        m = 0;
        while (f < 5000 && m < 7) begin f = f * 2; m++; end   // R3
        idx = 0;
        for (int k = 15; k >= 0; k--) if (f < edge_of(k)) idx = k;  // R4
        bp = 0; bq = 0; bd = 10000;                           // R6
        for (int p = 0; p < 128; p++) begin                   // R5
            for (int q = (5727 * (p + 3)) / 32767; q < 128; q++) begin
                int cf, d;
                cf = (5727 * (p + 3)) / (2 * (q + 2));
                d  = (f > cf) ? f - cf : cf - f;
                if (d < bd) begin bd = d; bp = p; bq = q; end
            end
        end
        word = {(mem ? 3'b101 : 3'b010), 4'(idx), 7'(bp), 3'(m), 7'(bq)};  // R7
    endtask

    // One full search with handshake and hold checks; optional mid-run start.
    task automatic run(input int freq, input int fmax, input bit allow, input bit mem,
                       input bit poke, output logic [23:0] w, output bit d);
        int n;
        bit busy_ok, hold_ok;
        logic [23:0] ew;
        bit ed;
        model(freq, fmax, allow, mem, ew, ed);
        @(negedge clk);
        freq_req = 16'(freq); freq_max = 16'(fmax); dbl_allow = allow; sel_mem = mem;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        busy_ok = 1'b1; hold_ok = 1'b1; n = 0;
        while (!done && n < 20000) begin
            if (!busy) busy_ok = 1'b0;
            if (n == 50) hold_ok = (prog_word === prev_word) && (dbl_on === prev_dbl);
            if (poke && n == 60) begin
                freq_req = 16'd9000; sel_mem = ~mem; dbl_allow = ~allow; start = 1'b1;
            end
            if (poke && n == 61) start = 1'b0;
            @(negedge clk);
            n++;
        end
        check(n < 20000, "R8 watchdog", n, 20000);
        check(busy_ok, "R8 busy during search", 0, 1);
        check(hold_ok, "R9 outputs held during search", prog_word, prev_word);
        check(!busy, "R8 idle at done", busy, 0);
        w = prog_word;
        d = dbl_on;
        check(w == ew, "R5 word matches exhaustive search", w, ew);
        check(d == ed, "R2 doubler flag", d, ed);
        @(negedge clk);
        check(!done, "R8 done one cycle", done, 0);
        repeat (5) @(negedge clk);
        check(prog_word == w && dbl_on == d, "R9 held after done", prog_word, w);
        prev_word = w;
        prev_dbl  = d;
    endtask

    task automatic t_reset();
        check(prog_word == 0, "R9 reset word", prog_word, 0);
        check(dbl_on == 0, "R9 reset flag", dbl_on, 0);
        check(!busy && !done, "R8 reset idle", {busy, done}, 0);
    endtask

    task automatic t_nominal();
        logic [23:0] w; bit d;
        run(6500, 20000, 1'b1, 1'b0, 1'b0, w, d);
        check(w[23:21] == 3'b010, "R7 pixel code", w[23:21], 3'b010);
        check(w[20:17] == 4'd5, "R4 band index", w[20:17], 5);
        check(w[9:7] == 3'd0, "R3 no scaling", w[9:7], 0);
    endtask

    task automatic t_zero();
        logic [23:0] w; bit d;
        run(0, 20000, 1'b0, 1'b1, 1'b0, w, d);
        check(w[23:21] == 3'b101, "R7 memory code", w[23:21], 3'b101);
        check(w[9:7] == 3'd1, "R1 zero becomes 3150 (m)", w[9:7], 1);
        check(w[20:17] == 4'd4, "R1 zero becomes 3150 (band)", w[20:17], 4);
    endtask

    task automatic t_doubler();
        logic [23:0] w; bit d;
        run(17000, 13500, 1'b1, 1'b0, 1'b0, w, d);
        check(d == 1'b1, "R2 doubler engaged", d, 1);
        check(w[20:17] == 4'd10, "R2 halved target band", w[20:17], 10);
    endtask

    task automatic t_no_doubler();
        logic [23:0] w; bit d;
        run(17000, 13500, 1'b0, 1'b0, 1'b0, w, d);
        check(d == 1'b0, "R2 doubler barred", d, 0);
        check(w[20:17] == 4'd0, "R4 no greater entry", w[20:17], 0);
    endtask

    task automatic t_tiny_ignore();
        logic [23:0] w; bit d;
        run(30, 20000, 1'b0, 1'b0, 1'b1, w, d);   // R8 mid-run start ignored
        check(w[9:7] == 3'd7, "R3 exponent saturates", w[9:7], 7);
        check(w[23:21] == 3'b010, "R8 ignored start kept select", w[23:21], 3'b010);
    endtask

    task automatic t_far();
        logic [23:0] w; bit d;
        run(40000, 40000, 1'b0, 1'b0, 1'b0, w, d);
        check(w[16:10] == 0 && w[6:0] == 0, "R6 no pair under bound", {w[16:10], w[6:0]}, 0);
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R8 global watchdog expired");
        report();
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; freq_req = '0; freq_max = '0;
        dbl_allow = 1'b0; sel_mem = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_nominal();
        t_zero();
        t_doubler();
        t_no_doubler();
        t_tiny_ignore();
        t_far();
        report();
        $finish;
    end
endmodule